// File: doc/BRIEF.md
# Pipelined Read Output Stage with Double-Cycle Deselect and Snooze

This block is the read-data end of a pipelined synchronous burst memory. A command decoder tells it on each rising clock edge whether a read address was accepted, whether a deselect was accepted, and whether any byte write was sampled. The memory array returns read data during the cycle after the address is accepted. This block registers that data into an output register. It then decides, cycle by cycle, whether the bidirectional data bus should be driven. The bus is modelled as a data vector `dq_out_o` plus a drive enable `dq_oe_o`, and the pad drivers sit outside.

Three mechanisms can switch the drive off. The first is a deselect, which keeps the bus driven for two further cycles before releasing it. The second is the asynchronous active-low output enable. The third is a snooze request, which passes through a synchronizer and then fixed entry and exit intervals. While the block sleeps, `sleep_o` tells the input stage to ignore every command, and the data already in the output register is kept.

The controller has six states:
- `ST_IDLE`: nothing in flight.
- `ST_ACTIVE`: a read was accepted on the last edge.
- `ST_DSEL`: the two-cycle deselect linger.
- `ST_ZZ_ENTER`: the entry interval.
- `ST_SLEEP`: snoozing.
- `ST_ZZ_EXIT`: the recovery interval.

The transitions are:
- Any of `ST_IDLE`, `ST_ACTIVE` or `ST_DSEL` goes to `ST_ZZ_ENTER` when the synchronized snooze request is high. This has the highest priority.
- Any of those three goes to `ST_IDLE` on a write.
- Any of those three goes to `ST_ACTIVE` on a read.
- `ST_ACTIVE` goes to `ST_DSEL` on a deselect. With no command at all it goes to `ST_IDLE`.
- `ST_DSEL` goes to `ST_IDLE` when its counter expires.
- `ST_ZZ_ENTER` goes to `ST_SLEEP` when its counter expires.
- `ST_SLEEP` goes to `ST_ZZ_EXIT` when the synchronized request falls.
- `ST_ZZ_EXIT` goes back to `ST_SLEEP` if the request rises again. Otherwise it goes to `ST_IDLE` when its counter expires.

Top module: `rdout_stage`

## Requirements
- R1: A read accepted on rising edge N with memory data D present during the following cycle shows D on `dq_out_o` from edge N+1 on. With `oe_n_i` low, `dq_oe_o` is 1 from edge N+1 on.
- R2: A deselect accepted on edge N right after a read keeps `dq_oe_o` at 1 for the two cycles that follow edges N and N+1, with the last read data held. `dq_oe_o` drops to 0 at edge N+2.
- R3: `oe_n_i` acts without a clock. While it is 1, `dq_oe_o` is 0. Returning it to 0 restores the drive within the same cycle. `dq_out_o` keeps updating while it is 1.
- R4: A write sampled on edge N forces `dq_oe_o` to 0 for the cycle after edge N, even with `oe_n_i` low and read data in the output register.
- R5: Reads accepted on consecutive edges with the memory data held constant present the same value again on every cycle, with the drive continuously on.
- R6: `sleep_o` rises on the edge that is 4 edges after the first edge that samples `zz_i` high. This is 2 synchronizer stages plus 2 entry cycles. Reads accepted before then still drive the bus. `dq_oe_o` is 0 whenever `sleep_o` is 1.
- R7: While `sleep_o` is 1, reads, deselects and writes are ignored. `dq_out_o` keeps the value it held when sleep began, and it still holds that value after `sleep_o` falls.
- R8: `sleep_o` falls on the edge that is 4 edges after the first edge that samples `zz_i` low. This is 2 synchronizer stages plus 2 exit cycles. A read accepted after that behaves as in R1.
- R9: During and after reset, `dq_oe_o` and `sleep_o` are 0 and `dq_out_o` is all zeros.
- R10: A read stream that ends with no deselect drives the last data for exactly one cycle. For a last read on edge N, `dq_oe_o` is 1 after edge N+1 and 0 after edge N+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low reset |
| rd_accept_i | input | 1 | Read address accepted on this edge (begin, continue or suspend) |
| mem_rdata_i | input | DATA_W | Array read data, valid in the cycle after an accept |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| wr_any_i | input | 1 | Any byte write sampled active on this edge |
| desel_i | input | 1 | Deselect command accepted on this edge |
| zz_i | input | 1 | Snooze request, active high, asynchronous |
| dq_out_o | output | DATA_W | Output data register |
| dq_oe_o | output | 1 | Bus drive enable |
| sleep_o | output | 1 | Snoozing or recovering; the input stage must ignore commands |

## Verification
The bench builds the block with its defaults: an 18-bit data path, two synchronizer stages, and two-cycle deselect, entry and exit intervals. With these values every latency is a small fixed edge count that the bench can predict by arithmetic. It sweeps burst lengths 1 to 4, each with the output enable both low and high, and checks every cycle of each burst and its deselect tail. It then walks a full snooze entry and exit edge by edge, showing the last non-sleeping and first sleeping cycle, then the last recovering and first awake cycle. Along the way it checks that commands issued during sleep leave the held data untouched.

// File: rtl/rdout_pkg.sv
package rdout_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_DSEL,
        ST_ZZ_ENTER,
        ST_SLEEP,
        ST_ZZ_EXIT
    } rdout_state_e;

endpackage

// File: rtl/rdout_sync.sv
module rdout_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rdout_pipe.sv
module rdout_pipe #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              rd_accept_i,
    input  logic              wr_any_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] data_o,
    output logic              out_vld_o,
    output logic              wr_q_o
);
    logic              addr_vld_q;
    logic [DATA_W-1:0] data_q;
    logic              out_vld_q;
    logic              wr_q;

    // stage 1: address accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_vld_q <= 1'b0;
            wr_q       <= 1'b0;
        end else begin
            addr_vld_q <= rd_accept_i & en_i;
            wr_q       <= wr_any_i & en_i;
        end
    end

    // stage 2: output data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q    <= '0;
            out_vld_q <= 1'b0;
        end else begin
            out_vld_q <= addr_vld_q & en_i;
            if (addr_vld_q && en_i) begin
                data_q <= mem_rdata_i;
            end
        end
    end

    assign data_o    = data_q;
    assign out_vld_o = out_vld_q;
    assign wr_q_o    = wr_q;
endmodule

// File: rtl/rdout_ctrl.sv
module rdout_ctrl
    import rdout_pkg::*;
#(
    parameter int DSEL_CYC  = 2,
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic zz_s_i,
    input  logic rd_accept_i,
    input  logic desel_i,
    input  logic wr_any_i,
    output logic sleep_o,
    output logic linger_o
);
    localparam int MAX_A  = (DSEL_CYC > ENTRY_CYC) ? DSEL_CYC : ENTRY_CYC;
    localparam int MAX_C  = (MAX_A > EXIT_CYC) ? MAX_A : EXIT_CYC;
    localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);
    localparam logic [CNT_W-1:0] DSEL_LD  = CNT_W'(DSEL_CYC - 1);
    localparam logic [CNT_W-1:0] ENTRY_LD = CNT_W'(ENTRY_CYC - 1);
    localparam logic [CNT_W-1:0] EXIT_LD  = CNT_W'(EXIT_CYC - 1);

    rdout_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic cnt_done;

    assign cnt_done = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_ACTIVE, ST_DSEL: begin
                if (zz_s_i) begin
                    state_d = ST_ZZ_ENTER;
                    cnt_d   = ENTRY_LD;
                end else if (wr_any_i) begin
                    state_d = ST_IDLE;
                end else if (rd_accept_i) begin
                    state_d = ST_ACTIVE;
                end else if (state_q == ST_ACTIVE) begin
                    if (desel_i) begin
                        state_d = ST_DSEL;
                        cnt_d   = DSEL_LD;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (state_q == ST_DSEL) begin
                    if (cnt_done) state_d = ST_IDLE;
                    else          cnt_d   = cnt_q - 1'b1;
                end
            end
            ST_ZZ_ENTER: begin
                if (cnt_done) state_d = ST_SLEEP;
                else          cnt_d   = cnt_q - 1'b1;
            end
            ST_SLEEP: begin
                if (!zz_s_i) begin
                    state_d = ST_ZZ_EXIT;
                    cnt_d   = EXIT_LD;
                end
            end
            ST_ZZ_EXIT: begin
                if (zz_s_i)        state_d = ST_SLEEP;
                else if (cnt_done) state_d = ST_IDLE;
                else               cnt_d   = cnt_q - 1'b1;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        sleep_o  = (state_q == ST_SLEEP) || (state_q == ST_ZZ_EXIT);
        linger_o = (state_q == ST_DSEL);
    end
endmodule

// File: rtl/rdout_stage.sv
module rdout_stage #(
    parameter int DATA_W      = 18,
    parameter int SYNC_STAGES = 2,
    parameter int DSEL_CYC    = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_accept_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              oe_n_i,
    input  logic              wr_any_i,
    input  logic              desel_i,
    input  logic              zz_i,
    output logic [DATA_W-1:0] dq_out_o,
    output logic              dq_oe_o,
    output logic              sleep_o
);
    logic zz_s;
    logic sleep;
    logic linger;
    logic out_vld;
    logic wr_q;

    rdout_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (zz_i),
        .sync_o  (zz_s)
    );

    rdout_ctrl #(
        .DSEL_CYC  (DSEL_CYC),
        .ENTRY_CYC (ENTRY_CYC),
        .EXIT_CYC  (EXIT_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .zz_s_i      (zz_s),
        .rd_accept_i (rd_accept_i),
        .desel_i     (desel_i),
        .wr_any_i    (wr_any_i),
        .sleep_o     (sleep),
        .linger_o    (linger)
    );

    rdout_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (~sleep),
        .rd_accept_i (rd_accept_i),
        .wr_any_i    (wr_any_i),
        .mem_rdata_i (mem_rdata_i),
        .data_o      (dq_out_o),
        .out_vld_o   (out_vld),
        .wr_q_o      (wr_q)
    );

    assign dq_oe_o = (out_vld | linger) & ~oe_n_i & ~sleep & ~wr_q;
    assign sleep_o = sleep;
endmodule

// File: rtl/rdout_stage_chk.sv
module rdout_stage_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_accept_i,
    input logic [DATA_W-1:0] mem_rdata_i,
    input logic              oe_n_i,
    input logic              wr_any_i,
    input logic [DATA_W-1:0] dq_out_o,
    input logic              dq_oe_o,
    input logic              sleep_o
);
    p_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_accept_i) && !$past(sleep_o) && !sleep_o)
            |=> (dq_out_o == $past(mem_rdata_i)));

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rd_accept_i) && !$past(rd_accept_i, 2) && !$past(rd_accept_i, 3))
            |-> !dq_oe_o);

    p_oe_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !dq_oe_o);

    p_write_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_any_i) && !$past(sleep_o)) |-> !dq_oe_o);

    p_sleep_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> !dq_oe_o);

    p_sleep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && $past(sleep_o)) |-> $stable(dq_out_o));
endmodule

bind rdout_stage rdout_stage_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_accept_i (rd_accept_i),
    .mem_rdata_i (mem_rdata_i),
    .oe_n_i      (oe_n_i),
    .wr_any_i    (wr_any_i),
    .dq_out_o    (dq_out_o),
    .dq_oe_o     (dq_oe_o),
    .sleep_o     (sleep_o)
);

// File: tb/rdout_stage_tb_top.sv
module rdout_stage_tb_top;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd = 1'b0;
    logic [DW-1:0] md = '0;
    logic          oe_n = 1'b0;
    logic          wr = 1'b0;
    logic          ds = 1'b0;
    logic          zz = 1'b0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          sleep;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rdout_stage dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_accept_i (rd),
        .mem_rdata_i (md),
        .oe_n_i      (oe_n),
        .wr_any_i    (wr),
        .desel_i     (ds),
        .zz_i        (zz),
        .dq_out_o    (dq_out),
        .dq_oe_o     (dq_oe),
        .sleep_o     (sleep)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic r, input logic d, input logic w, input logic [DW-1:0] data);
        rd = r; ds = d; wr = w; md = data;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [DW-1:0] dz;
        logic [DW-1:0] dn;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 oe in reset", 32'(dq_oe), 0);
        chk("R9 sleep in reset", 32'(sleep), 0);
        chk("R9 data in reset", 32'(dq_out), 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, '0);
        chk("R9 oe after reset", 32'(dq_oe), 0);

        // R1/R2/R3 sweep: burst length x output enable
        for (int ov = 0; ov < 2; ov++) begin
            for (int len = 1; len <= 4; len++) begin
                logic [DW-1:0] base;
                logic exp_oe;
                base = DW'(len * 18'h01111 + ov * 18'h20000);
                exp_oe = (ov == 0);
                oe_n = (ov != 0);
                cyc(1, 0, 0, '0);
                chk("R1 no drive before data", 32'(dq_oe), 0);
                for (int k = 1; k < len; k++) begin
                    cyc(1, 0, 0, base + DW'(k - 1));
                    chk("R1 data", 32'(dq_out), 32'(base + DW'(k - 1)));
                    chk("R1 R3 drive", 32'(dq_oe), 32'(exp_oe));
                end
                cyc(0, 1, 0, base + DW'(len - 1));
                chk("R2 data at deselect", 32'(dq_out), 32'(base + DW'(len - 1)));
                chk("R2 drive at deselect", 32'(dq_oe), 32'(exp_oe));
                cyc(0, 0, 0, '0);
                chk("R2 linger data", 32'(dq_out), 32'(base + DW'(len - 1)));
                chk("R2 linger drive", 32'(dq_oe), 32'(exp_oe));
                cyc(0, 0, 0, '0);
                chk("R2 released", 32'(dq_oe), 0);
            end
        end
        oe_n = 1'b0;

        // R10 read stream with no deselect
        cyc(1, 0, 0, '0);
        cyc(0, 0, 0, 18'h0ABCD);
        chk("R10 data", 32'(dq_out), 32'h0ABCD);
        chk("R10 drive one cycle", 32'(dq_oe), 1);
        cyc(0, 0, 0, '0);
        chk("R10 drive off", 32'(dq_oe), 0);

        // R5 suspend then R3 asynchronous OE
        cyc(1, 0, 0, '0);
        for (int i = 0; i < 3; i++) begin
            cyc(1, 0, 0, 18'h15A5A);
            chk("R5 repeated data", 32'(dq_out), 32'h15A5A);
            chk("R5 continuous drive", 32'(dq_oe), 1);
        end
        oe_n = 1'b1;
        #1;
        chk("R3 oe high no clock", 32'(dq_oe), 0);
        oe_n = 1'b0;
        #1;
        chk("R3 oe low restores", 32'(dq_oe), 1);

        // R4 write kills drive
        cyc(0, 0, 1, 18'h15A5A);
        chk("R4 write kill", 32'(dq_oe), 0);
        cyc(0, 0, 0, '0);
        chk("R4 stays off", 32'(dq_oe), 0);

        // R6 snooze entry with reads in flight
        dz = 18'h2C3C3;
        cyc(1, 0, 0, '0);
        cyc(1, 0, 0, dz);
        chk("R6 drive before snooze", 32'(dq_oe), 1);
        zz = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            cyc(1, 0, 0, dz);
            chk("R6 not yet asleep", 32'(sleep), 0);
        end
        chk("R6 in-flight drive", 32'(dq_oe), 1);
        cyc(1, 0, 0, dz);
        chk("R6 asleep", 32'(sleep), 1);
        chk("R6 hi-z asleep", 32'(dq_oe), 0);

        // R7 commands ignored in sleep
        for (int i = 0; i < 3; i++) begin
            cyc(1, (i == 2), (i == 1), 18'h3FFFF);
            chk("R7 data held", 32'(dq_out), 32'(dz));
            chk("R7 hi-z", 32'(dq_oe), 0);
        end

        // R8 exit
        zz = 1'b0;
        for (int i = 1; i <= 4; i++) begin
            cyc(0, 0, 0, '0);
            chk("R8 still recovering", 32'(sleep), 1);
        end
        cyc(0, 0, 0, '0);
        chk("R8 awake", 32'(sleep), 0);
        chk("R7 data retained", 32'(dq_out), 32'(dz));
        dn = 18'h01357;
        cyc(1, 0, 0, '0);
        cyc(0, 0, 0, dn);
        chk("R8 read after wake", 32'(dq_out), 32'(dn));
        chk("R8 drive after wake", 32'(dq_oe), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule